// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives a multi-channel analog-to-digital converter through one small control register. Software chooses a first channel, enables either trigger source, switches the converter's power on or off, selects one-shot or repeating operation and sets a run flag. Once the run flag is set and power is on, the sequencer asks the converter for one conversion per channel. It starts at the chosen first channel and counts upward to the highest channel. For each channel it raises a one-cycle start request, then waits for the converter's done handshake. On that handshake it emits a one-cycle result strobe that carries the channel number.

A run can be started in three ways: by software, by a falling edge on the active-low external trigger pin, or by a single-cycle on-chip event pulse. Each hardware source works only while its own enable bit is set. The two sources are ORed, and a hardware trigger sets the run flag exactly as software would. In one-shot mode, hardware clears the run flag after the highest channel has been converted. In repeating mode, the scan restarts from the first channel and the flag stays set. Any register write abandons the scan in progress.

The state machine has three states. IDLE waits for the run flag with power on. ISSUE drives the conversion request for one cycle. WAIT holds until done. The transitions are:
- IDLE to ISSUE when the run flag and the power bit are both set; this loads the first channel.
- ISSUE to WAIT unconditionally.
- WAIT to ISSUE on done when the channel is not the last; the channel is incremented.
- WAIT to ISSUE on done at the last channel in repeating mode; the first channel is reloaded.
- WAIT to IDLE on done at the last channel in one-shot mode; the run flag is cleared.
- Any state to IDLE on a register write.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the register reads 00h, `pwr_on` is 0 and neither `conv_start` nor `res_valid` is asserted.
- R2: A write stores `reg_wdata` in the register, and `reg_rdata` returns it from the next cycle. The bit layout is: bits 7:5 first channel, bit 4 external trigger enable, bit 3 on-chip event enable, bit 2 power, bit 1 repeating mode, bit 0 run flag. `pwr_on` follows bit 2.
- R3: A scan requests conversions for the first channel and then each higher channel up to 7, in ascending order. Each request is a one-cycle `conv_start` with the channel on `conv_chan`, and the next request waits for `conv_done`.
- R4: With first channel 7, a scan converts channel 7 only.
- R5: A register write aborts the scan in progress. No strobe is produced in the write cycle, and no request from the old scan follows. If the written value has the run flag set, a new scan begins from the new first channel.
- R6: Writing 1 to the run flag starts a scan. Writing 0 stops scanning.
- R7: In one-shot mode, the run flag reads 0 from the cycle after the strobe for channel 7, and no further request is made.
- R8: In repeating mode, the request after channel 7 is for the first channel again, and the run flag stays 1.
- R9: When bit 4 is set, a falling edge on `ext_trig_n` sets the run flag. The pin passes through a two-flop synchronizer before edge detection. When bit 4 is clear, the pin has no effect.
- R10: When bit 3 is set, a one-cycle `event_pulse` sets the run flag. When bit 3 is clear, the pulse has no effect.
- R11: When bit 2 is 0, no conversion is requested even if the run flag is 1.
- R12: A trigger that arrives while a scan is running is ignored. In one-shot mode, no extra scan follows the current one.
- R13: `res_valid` is high for exactly the cycle in which `conv_done` arrives in WAIT, and `res_chan` carries the converted channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ext_trig_n | input | 1 | Active-low external trigger pin (asynchronous) |
| event_pulse | input | 1 | Single-cycle on-chip trigger event |
| pwr_on | output | 1 | Converter power enable |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel of the current request |
| conv_done | input | 1 | Converter done handshake |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Channel of the strobed result |

## Verification
The bench builds the block with its default parameters: a 3-bit channel field, which gives eight channels, and a two-stage synchronizer. With these values a full walk from channel 0 to channel 7, the single-channel scan from 7, and the exact pin-to-flag delay of the external trigger can all be reached in short runs. The behavioural model in the bench answers each request with a done latency that rotates between one and three cycles. Writes and triggers therefore land in ISSUE, in WAIT and on the final channel.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } scan_state_t;

    localparam int BIT_RUN  = 0;
    localparam int BIT_REP  = 1;
    localparam int BIT_PWR  = 2;
    localparam int BIT_IEN  = 3;
    localparam int BIT_XEN  = 4;
    localparam int FIRST_LSB = 5;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] chain_q;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R9

endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_scan_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             ext_fall,
    input  logic             event_pulse,
    input  logic             busy,
    input  logic             seq_end,
    output logic [REG_W-1:0] ctrl_q
);
    logic trig_hit;

    assign trig_hit = ((ext_fall & ctrl_q[BIT_XEN]) |
                       (event_pulse & ctrl_q[BIT_IEN])) & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr) begin
            ctrl_q <= reg_wdata;
        end else if (trig_hit) begin
            ctrl_q[BIT_RUN] <= 1'b1;
        end else if (seq_end) begin
            ctrl_q[BIT_RUN] <= 1'b0;
        end
    end

    AST_TRIG_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !reg_wr) |=> ctrl_q[BIT_RUN]); // R9

    AST_SINGLE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && !reg_wr) |=> !ctrl_q[BIT_RUN]); // R7

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            run,
    input  logic            pwr,
    input  logic            rep,
    input  logic [CH_W-1:0] first_ch,
    input  logic            conv_done,
    output logic            busy,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            res_valid,
    output logic [CH_W-1:0] res_chan,
    output logic            seq_end
);
    localparam logic [CH_W-1:0] LAST_CH = {CH_W{1'b1}};

    scan_state_t     state_q, state_d;
    logic [CH_W-1:0] chan_q, chan_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        unique case (state_q)
            S_IDLE: begin
                if (run && pwr) begin
                    state_d = S_ISSUE;
                    chan_d  = first_ch;
                end
            end
            S_ISSUE: state_d = S_WAIT;
            S_WAIT: begin
                if (conv_done) begin
                    if (chan_q != LAST_CH) begin
                        state_d = S_ISSUE;
                        chan_d  = chan_q + 1'b1;
                    end else if (rep) begin
                        state_d = S_ISSUE;
                        chan_d  = first_ch;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (abort) state_d = S_IDLE;
    end

    always_comb begin
        busy       = (state_q != S_IDLE);
        conv_start = (state_q == S_ISSUE);
        conv_chan  = chan_q;
        res_chan   = chan_q;
        res_valid  = (state_q == S_WAIT) && conv_done && !abort;
        seq_end    = res_valid && (chan_q == LAST_CH) && !rep;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R3

    AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!conv_start && !res_valid)); // R5

    AST_NO_START_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> pwr); // R11

    AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_chan >= first_ch)); // R3

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R13

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int SYNC_STAGES = 2,
    localparam int REG_W      = CH_W + FIRST_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ext_trig_n,
    input  logic             event_pulse,
    output logic             pwr_on,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_chan
);
    logic             ext_fall;
    logic             busy;
    logic             seq_end;
    logic [REG_W-1:0] ctrl_q;

    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_trig_n),
        .fall  (ext_fall)
    );

    adc_ctrl_reg #(.REG_W(REG_W)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .ext_fall    (ext_fall),
        .event_pulse (event_pulse),
        .busy        (busy),
        .seq_end     (seq_end),
        .ctrl_q      (ctrl_q)
    );

    adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (reg_wr),
        .run        (ctrl_q[BIT_RUN]),
        .pwr        (ctrl_q[BIT_PWR]),
        .rep        (ctrl_q[BIT_REP]),
        .first_ch   (ctrl_q[REG_W-1:FIRST_LSB]),
        .conv_done  (conv_done),
        .busy       (busy),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .res_valid  (res_valid),
        .res_chan   (res_chan),
        .seq_end    (seq_end)
    );

    assign reg_rdata = ctrl_q;
    assign pwr_on    = ctrl_q[BIT_PWR];

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_trig_n = 1'b1;
    logic       event_pulse = 1'b0;
    logic       pwr_on;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic       conv_done = 1'b0;
    logic       res_valid;
    logic [2:0] res_chan;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ext_trig_n  (ext_trig_n),
        .event_pulse (event_pulse),
        .pwr_on      (pwr_on),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .conv_done   (conv_done),
        .res_valid   (res_valid),
        .res_chan    (res_chan)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    lat_cnt = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model state
    int       m_phase = 0;   // 0 idle, 1 request, 2 waiting
    int       m_ch = 0;
    bit [7:0] m_reg = 8'h00;
    bit       p1 = 1, p2 = 1, p3 = 1;

    task automatic chk(input string sig, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", cur_req, sig, act, exp, cyc);
        end
    endtask

    task automatic step(input bit wr, input bit [7:0] wd, input bit xn, input bit ev);
        bit exp_start, exp_rv, fall, trig;
        @(negedge clk);
        cyc++;
        reg_wr      = wr;
        reg_wdata   = wd;
        ext_trig_n  = xn;
        event_pulse = ev;
        conv_done   = (lat_cnt == 1);
        if (lat_cnt > 0) lat_cnt--;
        #1;
        exp_start = (m_phase == 1);
        exp_rv    = (m_phase == 2) && conv_done && !wr;
        chk("reg_rdata", reg_rdata, m_reg);
        chk("pwr_on", pwr_on, m_reg[2]);
        chk("conv_start", conv_start, exp_start);
        chk("res_valid", res_valid, exp_rv);
        if (exp_start) chk("conv_chan", conv_chan, m_ch);
        if (exp_rv)    chk("res_chan", res_chan, m_ch);
        if (conv_start) lat_cnt = 1 + (cyc % 3);
        // model advance
        fall = p3 && !p2;
        trig = ((fall && m_reg[4]) || (ev && m_reg[3])) && (m_phase == 0);
        p3 = p2; p2 = p1; p1 = xn;
        if (wr) begin
            m_reg   = wd;
            m_phase = 0;
        end else begin
            if (m_phase == 0) begin
                if (m_reg[0] && m_reg[2]) begin
                    m_phase = 1;
                    m_ch    = m_reg[7:5];
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (conv_done) begin
                if (m_ch != 7) begin
                    m_ch++;
                    m_phase = 1;
                end else if (m_reg[1]) begin
                    m_ch    = m_reg[7:5];
                    m_phase = 1;
                end else begin
                    m_phase  = 0;
                    m_reg[0] = 1'b0;
                end
            end
            if (trig) m_reg[0] = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 1, 0);
    endtask

    task automatic wr_reg(input bit [7:0] d);
        step(1, d, 1, 0);
    endtask

    task automatic ext_pulse();
        for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 0);
    endtask

    task automatic evt();
        step(0, 8'h00, 1, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        cur_req = "R1";            idle(3);
        cur_req = "R2";            wr_reg(8'hA4); idle(5);
        cur_req = "R3 R7 R13";     wr_reg(8'h25); idle(40);
        cur_req = "R4";            wr_reg(8'hE5); idle(15);
        cur_req = "R8";            wr_reg(8'h47); idle(50);
        cur_req = "R6";            wr_reg(8'h46); idle(10);
        wr_reg(8'h45); idle(30);
        cur_req = "R5";            wr_reg(8'h05); idle(5);
        wr_reg(8'h65); idle(4);
        wr_reg(8'hA5); idle(30);
        cur_req = "R11";           wr_reg(8'h01); idle(10);
        cur_req = "R9";            wr_reg(8'h94); idle(2); ext_pulse(); idle(30);
        wr_reg(8'h84); idle(2); ext_pulse(); idle(10);
        cur_req = "R10";           wr_reg(8'hCC); evt(); idle(20);
        wr_reg(8'hC4); evt(); idle(10);
        cur_req = "R12";           wr_reg(8'hDC); evt(); idle(3); evt();
        step(0, 8'h00, 0, 0); step(0, 8'h00, 0, 0); idle(25);
        summary();
    end

endmodule